// File: doc/BRIEF.md
# Clock-Calendar Update Engine

This block holds a wall-clock time and calendar (seconds, minutes, hours, weekday, day of month, month, two-digit year) and steps it forward by one second each time a one-second tick arrives. The time lives in two copies. The internal copy is always kept in plain binary with a 0-23 hour, and it advances on every tick. The user copy is the one seen through the byte port. It is held in the byte format chosen by the format inputs, and the internal copy is transferred into it after each step.

The format inputs select binary or BCD bytes and a 24-hour or 12-hour hour byte. In 12-hour mode bit 7 of the hour byte marks PM. The calendar handles month lengths and leap Februaries. A daylight-saving option adds a spring-forward jump and a single fall-back repeat. Three alarm bytes are compared against the new hours, minutes and seconds on each step. A one-cycle alarm pulse and a one-cycle step-done pulse report the result to the interrupt logic around the block.

A hold input freezes the user copy so software can write a new time. When the hold is released, a time that was written during the hold is loaded into the internal copy. If nothing was written, the user copy catches up with the time that kept running internally.

Top module: `rtc_calendar_engine`

## Requirements
- R1: After reset every location reads 00h except weekday, day of month and month, which read 01h; both event outputs are low.
- R2: Each tick advances the time by one second, carrying seconds into minutes and minutes into hours at 59, and hours into the next day after 23. `update_evt` is high for exactly the one cycle after each tick edge.
- R3: With `bin_mode`=1 every time byte holds the plain binary value. With `bin_mode`=0 it holds two BCD digits, the tens digit in bits 7:4 (for example ten o'clock reads 10h).
- R4: With `hour24`=0 the hour byte holds 1-12 and bit 7 set means PM. Midnight reads 12 with bit 7 clear (12h in BCD), and noon reads 12 with bit 7 set (92h in BCD). With `hour24`=1 the hour byte runs 0-23.
- R5: Weekday runs 1-7 (1 = Sunday) and wraps from 7 to 1. Day of month wraps after 30 in April, June, September and November, and after 31 in the other months except February. February has 29 days when year mod 4 = 0 (including 00) and 28 days otherwise. December rolls into January, and year 99 rolls into 00.
- R6: With `dst_en`=1, in April on a Sunday whose day of month is 1-7, the second after 1:59:59 is 3:00:00. With `dst_en`=0 it is 2:00:00.
- R7: With `dst_en`=1, in October on a Sunday whose day of month is 25 or later, the second after 1:59:59 is 1:00:00. This happens once: the repeated 1:59:59 goes on to 2:00:00. The one-shot rearms at the next midnight rollover.
- R8: Locations 1, 3 and 5 are the second, minute and hour alarm bytes; an alarm byte with bits 7:6 = 11 matches anything. `alarm_evt` pulses together with `update_evt` when all three alarm bytes match the new encoded time and `set_hold`=0.
- R9: While `set_hold`=1 the user copy does not change on ticks, and writes to the time locations (0, 2, 4, 6, 7, 8, 9) are accepted. While `set_hold`=0 writes to time locations have no effect. Alarm locations are writable at any time.
- R10: On release of `set_hold`, if a time location was written during the hold, counting resumes from the written time. Otherwise the user copy shows the internal time, which kept advancing on ticks during the hold.
- R11: `rd_data` shows the location selected by `addr` one clock later. Addresses 10 and above read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| set_hold | input | 1 | Freeze user copy and allow time writes |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| dst_en | input | 1 | Enable daylight-saving jumps |
| wr_en | input | 1 | Byte write strobe |
| addr | input | ADDR_W | Location select |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Registered read byte |
| alarm_evt | output | 1 | Alarm match pulse |
| update_evt | output | 1 | Step-done pulse |

## Verification
The assertions assume that every time written during a hold is a legal value in the format selected at that moment. They also assume that ticks are single-cycle pulses and that the format inputs change only while the hold is set. The stimulus builds each random time from legal ranges (day of month bounded by that month's length) and writes it in the active format under hold. It only changes `bin_mode` and `hour24` inside that hold window. Random starting points are biased toward the last seconds of a minute so that the carries and rollovers get exercised.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_LOC = 10;

  localparam int LOC_SEC  = 0;
  localparam int LOC_ASEC = 1;
  localparam int LOC_MIN  = 2;
  localparam int LOC_AMIN = 3;
  localparam int LOC_HR   = 4;
  localparam int LOC_AHR  = 5;
  localparam int LOC_DOW  = 6;
  localparam int LOC_DOM  = 7;
  localparam int LOC_MON  = 8;
  localparam int LOC_YR   = 9;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t yr;
    byte_t mon;
    byte_t dom;
    byte_t dow;
    byte_t hr;
    byte_t mins;
    byte_t sec;
  } rtc_time_t;

  function automatic byte_t bin2bcd(byte_t v);
    byte_t t;
    byte_t o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic byte_t bcd2bin(byte_t v);
    return byte_t'(v[7:4]) * 8'd10 + byte_t'(v[3:0]);
  endfunction

  function automatic byte_t enc_val(byte_t v, logic bin);
    return bin ? v : bin2bcd(v);
  endfunction

  function automatic byte_t dec_val(byte_t v, logic bin);
    return bin ? v : bcd2bin(v);
  endfunction

  function automatic byte_t enc_hour(byte_t h, logic bin, logic h24);
    byte_t h12;
    byte_t e;
    if (h24) return enc_val(h, bin);
    h12 = h % 8'd12;
    if (h12 == 8'd0) h12 = 8'd12;
    e = enc_val(h12, bin);
    return {(h >= 8'd12), e[6:0]};
  endfunction

  function automatic byte_t dec_hour(byte_t b, logic bin, logic h24);
    byte_t h;
    if (h24) return dec_val(b, bin);
    h = dec_val({1'b0, b[6:0]}, bin);
    if (h == 8'd12) h = 8'd0;
    if (b[7]) h = h + 8'd12;
    return h;
  endfunction

  function automatic byte_t days_in_month(byte_t mon, byte_t yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
  import rtc_cal_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      dst_en,
  input  logic      fb_done,
  output rtc_time_t nxt,
  output logic      fb_fire,
  output logic      day_roll
);
  logic  at_159;
  logic  spring;
  logic  fall;
  byte_t dim;

  always_comb begin
    at_159 = (cur.hr == 8'd1) && (cur.mins == 8'd59) && (cur.sec == 8'd59);
    spring = dst_en && at_159 && (cur.mon == 8'd4) && (cur.dow == 8'd1) && (cur.dom <= 8'd7);
    fall   = dst_en && at_159 && (cur.mon == 8'd10) && (cur.dow == 8'd1) &&
             (cur.dom >= 8'd25) && !fb_done;
    dim    = days_in_month(cur.mon, cur.yr);
  end

  always_comb begin
    nxt      = cur;
    fb_fire  = 1'b0;
    day_roll = 1'b0;
    if (cur.sec != 8'd59) begin
      nxt.sec = cur.sec + 8'd1;
    end else begin
      nxt.sec = 8'd0;
      if (cur.mins != 8'd59) begin
        nxt.mins = cur.mins + 8'd1;
      end else begin
        nxt.mins = 8'd0;
        if (spring) begin
          nxt.hr = 8'd3;
        end else if (fall) begin
          nxt.hr  = 8'd1;
          fb_fire = 1'b1;
        end else if (cur.hr != 8'd23) begin
          nxt.hr = cur.hr + 8'd1;
        end else begin
          nxt.hr   = 8'd0;
          day_roll = 1'b1;
          nxt.dow  = (cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1;
          if (cur.dom < dim) begin
            nxt.dom = cur.dom + 8'd1;
          end else begin
            nxt.dom = 8'd1;
            if (cur.mon < 8'd12) begin
              nxt.mon = cur.mon + 8'd1;
            end else begin
              nxt.mon = 8'd1;
              nxt.yr  = (cur.yr >= 8'd99) ? 8'd0 : cur.yr + 8'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NUM_FIELDS = 3,
  parameter int FW         = 8
) (
  input  logic [NUM_FIELDS*FW-1:0] now_bytes,
  input  logic [NUM_FIELDS*FW-1:0] alm_bytes,
  output logic                     hit
);
  logic [NUM_FIELDS-1:0] fmatch;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FW-1:0] a;
    logic [FW-1:0] n;
    assign a = alm_bytes[i*FW +: FW];
    assign n = now_bytes[i*FW +: FW];
    assign fmatch[i] = (a[FW-1:FW-2] == 2'b11) || (a == n);
  end

  assign hit = &fmatch;
endmodule

// File: rtl/rtc_calendar_engine.sv
module rtc_calendar_engine
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              set_hold,
  input  logic              bin_mode,
  input  logic              hour24,
  input  logic              dst_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              alarm_evt,
  output logic              update_evt
);
  localparam int IDX_W = $clog2(NUM_LOC);

  byte_t     usr [NUM_LOC];
  rtc_time_t tcur;
  logic      set_q;
  logic      dirty;
  logic      fb_done;

  rtc_time_t usr_t;
  rtc_time_t base;
  rtc_time_t nxt;
  rtc_time_t tgt;
  logic      fb_fire;
  logic      day_roll;
  logic      set_fall;
  logic      addr_ok;
  logic      is_alm;
  logic      wr_ok;
  logic      wr_time;
  logic      hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    usr_t.sec  = dec_val(usr[LOC_SEC], bin_mode);
    usr_t.mins = dec_val(usr[LOC_MIN], bin_mode);
    usr_t.hr   = dec_hour(usr[LOC_HR], bin_mode, hour24);
    usr_t.dow  = dec_val(usr[LOC_DOW], bin_mode);
    usr_t.dom  = dec_val(usr[LOC_DOM], bin_mode);
    usr_t.mon  = dec_val(usr[LOC_MON], bin_mode);
    usr_t.yr   = dec_val(usr[LOC_YR], bin_mode);
  end

  assign set_fall = set_q && !set_hold;
  assign base     = (set_fall && dirty) ? usr_t : tcur;
  assign tgt      = tick_1hz ? nxt : base;

  rtc_time_step u_step (
    .cur      (base),
    .dst_en   (dst_en),
    .fb_done  (fb_done),
    .nxt      (nxt),
    .fb_fire  (fb_fire),
    .day_roll (day_roll)
  );

  rtc_alarm_cmp #(.NUM_FIELDS(3), .FW(BYTE_W)) u_alarm (
    .now_bytes ({enc_hour(nxt.hr, bin_mode, hour24),
                 enc_val(nxt.mins, bin_mode),
                 enc_val(nxt.sec, bin_mode)}),
    .alm_bytes ({usr[LOC_AHR], usr[LOC_AMIN], usr[LOC_ASEC]}),
    .hit       (hit)
  );

  always_comb begin
    idx     = addr[IDX_W-1:0];
    addr_ok = (int'(addr) < NUM_LOC);
    is_alm  = (int'(addr) == LOC_ASEC) || (int'(addr) == LOC_AMIN) || (int'(addr) == LOC_AHR);
    wr_ok   = wr_en && addr_ok && (is_alm || set_hold);
    wr_time = wr_ok && !is_alm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LOC; i++)
        usr[i] <= (i == LOC_DOW || i == LOC_DOM || i == LOC_MON) ? 8'd1 : 8'd0;
      tcur       <= '{yr: 8'd0, mon: 8'd1, dom: 8'd1, dow: 8'd1, hr: 8'd0, mins: 8'd0, sec: 8'd0};
      set_q      <= 1'b0;
      dirty      <= 1'b0;
      fb_done    <= 1'b0;
      rd_data    <= '0;
      alarm_evt  <= 1'b0;
      update_evt <= 1'b0;
    end else begin
      set_q <= set_hold;

      if (tick_1hz)               tcur <= nxt;
      else if (set_fall && dirty) tcur <= usr_t;

      if (tick_1hz && day_roll)     fb_done <= 1'b0;
      else if (tick_1hz && fb_fire) fb_done <= 1'b1;

      if (set_fall)     dirty <= 1'b0;
      else if (wr_time) dirty <= 1'b1;

      if (!set_hold && (tick_1hz || set_fall)) begin
        usr[LOC_SEC] <= enc_val(tgt.sec, bin_mode);
        usr[LOC_MIN] <= enc_val(tgt.mins, bin_mode);
        usr[LOC_HR]  <= enc_hour(tgt.hr, bin_mode, hour24);
        usr[LOC_DOW] <= enc_val(tgt.dow, bin_mode);
        usr[LOC_DOM] <= enc_val(tgt.dom, bin_mode);
        usr[LOC_MON] <= enc_val(tgt.mon, bin_mode);
        usr[LOC_YR]  <= enc_val(tgt.yr, bin_mode);
      end
      if (wr_ok) usr[idx] <= wr_data;

      rd_data    <= addr_ok ? usr[idx] : '0;
      update_evt <= tick_1hz;
      alarm_evt  <= tick_1hz && !set_hold && hit;
    end
  end

  // Step-done pulse only ever follows a tick edge (R2)
  assert_update_follows_tick_R2: assert property (@(posedge clk) disable iff (rst)
    update_evt |-> $past(tick_1hz));

  // Internal seconds advance by one modulo 60 on a plain tick (R2)
  assert_sec_step_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tick_1hz) && !$past(set_fall))
      |-> (tcur.sec == byte_t'(($past(tcur.sec) + 8'd1) % 8'd60)));

  // Internal calendar stays within its legal ranges (R5)
  assert_cal_range_R5: assert property (@(posedge clk) disable iff (rst)
    (tcur.dow >= 8'd1) && (tcur.dow <= 8'd7) && (tcur.mon >= 8'd1) && (tcur.mon <= 8'd12) &&
    (tcur.hr < 8'd24) && (tcur.mins < 8'd60) && (tcur.yr < 8'd100));

  // Alarm pulse never appears without a step-done pulse (R8)
  assert_alarm_with_update_R8: assert property (@(posedge clk) disable iff (rst)
    alarm_evt |-> update_evt);

  // User seconds byte is frozen while held and not written (R9)
  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(set_hold) && !$past(wr_en)) |-> $stable(usr[LOC_SEC]));
endmodule

// File: tb/sim_rtc_calendar_engine.sv
module sim_rtc_calendar_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0, set_hold = 1'b0, bin_mode = 1'b1, hour24 = 1'b1, dst_en = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic alarm_evt, update_evt;

  int tests = 0, fails = 0;
  bit finished = 0;
  int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr;
  bit m_fb = 0;
  int a_sec = 0, a_min = 0, a_hr = 0;

  always #4 clk = ~clk;

  rtc_calendar_engine u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .set_hold(set_hold), .bin_mode(bin_mode),
    .hour24(hour24), .dst_en(dst_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .alarm_evt(alarm_evt), .update_evt(update_evt));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int enc(int v, bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int enc_h(int h, bit bin, bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 128 : 0) + enc(h12, bin);
  endfunction

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic bit amatch(int a, int v);
    return ((a & 8'hC0) == 8'hC0) || (a == v);
  endfunction

  task automatic model_step();
    bit at159;
    at159 = (m_hr == 1 && m_min == 59 && m_sec == 59);
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (dst_en && at159 && m_mon == 4 && m_dow == 1 && m_dom <= 7) m_hr = 3;
    else if (dst_en && at159 && m_mon == 10 && m_dow == 1 && m_dom >= 25 && !m_fb) begin
      m_hr = 1; m_fb = 1;
    end else if (m_hr < 23) m_hr++;
    else begin
      m_hr = 0; m_fb = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      if (m_dom < dim(m_mon, m_yr)) m_dom++;
      else begin
        m_dom = 1;
        if (m_mon < 12) m_mon++;
        else begin m_mon = 1; m_yr = (m_yr == 99) ? 0 : m_yr + 1; end
      end
    end
  endtask

  task automatic write_byte(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_byte(int a, output int d);
    @(negedge clk); addr = 4'(a);
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic load_time(bit bin, bit h24, int hr, int mn, int sc, int dw, int dm, int mo, int yr);
    @(negedge clk); set_hold = 1'b1; bin_mode = bin; hour24 = h24;
    m_hr = hr; m_min = mn; m_sec = sc; m_dow = dw; m_dom = dm; m_mon = mo; m_yr = yr;
    write_byte(0, enc(sc, bin));
    write_byte(2, enc(mn, bin));
    write_byte(4, enc_h(hr, bin, h24));
    write_byte(6, enc(dw, bin));
    write_byte(7, enc(dm, bin));
    write_byte(8, enc(mo, bin));
    write_byte(9, enc(yr, bin));
    @(negedge clk); set_hold = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_tick();
    bit exp_al;
    @(negedge clk); tick_1hz = 1'b1;
    model_step();
    exp_al = !set_hold && amatch(a_sec, enc(m_sec, bin_mode)) && amatch(a_min, enc(m_min, bin_mode))
             && amatch(a_hr, enc_h(m_hr, bin_mode, hour24));
    @(negedge clk); tick_1hz = 1'b0;
    chk("R2 update_evt", int'(update_evt), 1);
    chk("R8 alarm_evt", int'(alarm_evt), int'(exp_al));
    @(negedge clk);
    chk("R2 update_evt width", int'(update_evt), 0);
  endtask

  task automatic check_time(string req);
    int v;
    read_byte(0, v); chk({req, " sec"}, v, enc(m_sec, bin_mode));
    read_byte(2, v); chk({req, " min"}, v, enc(m_min, bin_mode));
    read_byte(4, v); chk({req, " hour"}, v, enc_h(m_hr, bin_mode, hour24));
    read_byte(6, v); chk({req, " dow"}, v, enc(m_dow, bin_mode));
    read_byte(7, v); chk({req, " dom"}, v, enc(m_dom, bin_mode));
    read_byte(8, v); chk({req, " month"}, v, enc(m_mon, bin_mode));
    read_byte(9, v); chk({req, " year"}, v, enc(m_yr, bin_mode));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, sv;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R11 out-of-range read
    chk("R1 update_evt", int'(update_evt), 0);
    chk("R1 alarm_evt", int'(alarm_evt), 0);
    for (int a = 0; a < 10; a++) begin
      read_byte(a, v);
      chk("R1 reset byte", v, (a == 6 || a == 7 || a == 8) ? 1 : 0);
    end
    write_byte(12, 8'h5A);
    read_byte(12, v); chk("R11 unused address", v, 0);

    // R2 R5 full rollover into a new century
    load_time(1, 1, 23, 59, 59, 7, 31, 12, 99);
    do_tick(); check_time("R2 R5 new year");
    chk("R5 year wrap", m_yr, 0);

    // R5 leap years
    load_time(1, 1, 23, 59, 59, 3, 28, 2, 4);
    do_tick(); check_time("R5 leap feb29");
    load_time(0, 1, 23, 59, 59, 3, 28, 2, 1);
    do_tick(); check_time("R5 nonleap mar1");
    load_time(0, 1, 23, 59, 59, 3, 29, 2, 0);
    do_tick(); check_time("R5 year00 leap");

    // R3 BCD tens digit
    load_time(0, 1, 9, 59, 59, 2, 10, 5, 20);
    do_tick();
    read_byte(4, v); chk("R3 bcd hour 10", v, 8'h10);

    // R4 12-hour midnight and noon
    load_time(0, 0, 23, 59, 59, 2, 10, 5, 20);
    do_tick();
    read_byte(4, v); chk("R4 midnight", v, 8'h12);
    load_time(0, 0, 11, 59, 59, 2, 10, 5, 20);
    do_tick();
    read_byte(4, v); chk("R4 noon", v, 8'h92);

    // R6 spring forward, enabled and disabled
    dst_en = 1'b1;
    load_time(1, 1, 1, 59, 59, 1, 2, 4, 30);
    do_tick();
    read_byte(4, v); chk("R6 spring jump", v, 3);
    dst_en = 1'b0;
    load_time(1, 1, 1, 59, 59, 1, 2, 4, 30);
    do_tick();
    read_byte(4, v); chk("R6 no jump when off", v, 2);

    // R7 fall back once
    dst_en = 1'b1;
    load_time(0, 1, 1, 59, 59, 1, 30, 10, 30);
    do_tick();
    check_time("R7 fall back");
    repeat (3599) do_tick();
    check_time("R7 before second pass");
    do_tick();
    read_byte(4, v); chk("R7 no second repeat", v, 2);
    dst_en = 1'b0;

    // R8 alarm exact, mismatch, don't-care
    load_time(0, 1, 10, 20, 30, 3, 5, 6, 21);
    a_sec = 8'h31; a_min = 8'h20; a_hr = 8'h10;
    write_byte(1, a_sec); write_byte(3, a_min); write_byte(5, a_hr);
    do_tick();
    do_tick();
    a_sec = 8'hC0; a_min = 8'hC5; a_hr = 8'hFF;
    write_byte(1, a_sec); write_byte(3, a_min); write_byte(5, a_hr);
    do_tick();
    a_hr = 8'h11; write_byte(5, a_hr);
    do_tick();

    // R9 time write ignored while not held, alarm write accepted
    write_byte(0, 8'h33);
    read_byte(0, v); chk("R9 time write ignored", v, enc(m_sec, bin_mode));
    write_byte(1, 8'h44); a_sec = 8'h44;
    read_byte(1, v); chk("R9 alarm write", v, 8'h44);

    // R9 frozen during hold, R10 catch-up on release without writes
    sv = enc(m_sec, bin_mode);
    @(negedge clk); set_hold = 1'b1;
    repeat (3) do_tick();
    read_byte(0, v); chk("R9 frozen seconds", v, sv);
    @(negedge clk); set_hold = 1'b0;
    @(negedge clk);
    check_time("R10 catch-up");

    // R2 R3 R4 R5 random starting points near rollovers
    for (int it = 0; it < 60; it++) begin
      int mo, yr, dm;
      bit b, h;
      b = $urandom % 2; h = $urandom % 2;
      dst_en = $urandom % 2;
      mo = 1 + $urandom % 12; yr = $urandom % 100; dm = 1 + $urandom % dim(mo, yr);
      if ($urandom % 3 == 0) dm = dim(mo, yr);
      load_time(b, h, ($urandom % 2) ? 23 : $urandom % 24, 58 + $urandom % 2, 56 + $urandom % 4,
                1 + $urandom % 7, dm, mo, yr);
      repeat (1 + $urandom % 4) do_tick();
      check_time("R2 R3 R4 R5 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule